// File: doc/BRIEF.md
# Protected-Write Clock Prescaler

This block turns a master clock into a periodic enable for the logic that runs on a slower system rate. The enable is high for one master-clock cycle out of every 2^n cycles. The exponent n comes from a 4-bit select field in a small control register on a plain write-strobe bus. A stray write must not change the clock rate, so the select field is guarded. Software first writes a lone unlock bit. That opens a window of four master-clock cycles, and during that window one write may load a new select code.

A configuration input picks the select code loaded at reset. When it is low the block comes out of reset at divide-by-1. When it is high it comes out at divide-by-8. Software may later load any code through the unlock sequence, whatever this input was. Software must keep interrupts from splitting the two writes of the sequence.

Top module: `clk_scaler_guarded`

## Requirements
- R1: The read word holds the unlock flag in bit 7 and the select code in bits 3..0. Bits 6..4 always read zero, and writes to them have no effect.
- R2: The unlock flag sets only after a write whose data is exactly 0x80. Any other write leaves a clear flag clear.
- R3: Once set, the unlock flag stays set for four master-clock cycles and then clears by itself. A select write is accepted on any of the four clock edges after the arming write, and is refused on the fifth.
- R4: An accepted select write (a write with bit 7 zero while the flag is set) clears the flag at the same clock edge.
- R5: Writing 0x80 again, or any other data with bit 7 set, while the flag is set neither restarts the four-cycle window nor clears the flag.
- R6: While the flag is clear, writes with bit 7 zero are dropped, and the select code keeps its value.
- R7: Reset loads select code 0 when the reset-configuration input is low, and code 3 when it is high.
- R8: Every select code can be loaded through the unlock sequence under either reset configuration.
- R9: Code n from 0 to 8 selects a period of 2^n cycles. Codes 9 to 15 are refused: the previous code stays, but the write still closes the window.
- R10: The enable is high for exactly one cycle in each period. At code 0 it is high in every cycle.
- R11: When the select code changes, the period restarts. The enable is high in the first cycle after the accepting edge, and then every 2^n cycles after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div8 | input | 1 | Reset configuration: high selects divide-by-8 at reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| tick_o | output | 1 | System clock enable, one master cycle per period |

## Verification
The assertions assume that cfg_div8 is steady while rst_n is low. They also assume that the unlock flag and the select code seen on rd_data are the register's state, with no bus transaction in flight. The bench changes cfg_div8 only before it asserts reset. It drives wr_en and wr_data at the falling clock edge, one write per cycle, so every write is seen by exactly one rising edge. It sweeps all sixteen codes under both reset configurations, and it places select writes on each side of the edge where the unlock window ends.

// File: rtl/clk_scaler_pkg.sv
package clk_scaler_pkg;

   typedef enum logic [1:0] {
      ROLE_GATE = 2'd0,
      ROLE_SEL  = 2'd1,
      ROLE_RSV  = 2'd2
   } bit_role_e;

   function automatic bit_role_e bit_role(input int idx, input int gate_bit, input int sel_w);
      if (idx == gate_bit)  return ROLE_GATE;
      else if (idx < sel_w) return ROLE_SEL;
      else                  return ROLE_RSV;
   endfunction

   function automatic logic [31:0] reserved_mask(input int data_w, input int gate_bit, input int sel_w);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < data_w; i++)
         if (bit_role(i, gate_bit, sel_w) == ROLE_RSV) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cs_unlock_gate.sv
module cs_unlock_gate #(
   parameter int DATA_W   = 8,
   parameter int GATE_BIT = 7,
   parameter int WINDOW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              open_o,
   output logic              commit_o
);
   localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam logic [DATA_W-1:0] ARM_WORD = DATA_W'(1) << GATE_BIT;

   logic          open_q;
   logic [CW-1:0] left_q;
   logic          arm_req;

   assign arm_req  = wr_en && (wr_data == ARM_WORD);
   assign commit_o = open_q && wr_en && !wr_data[GATE_BIT];
   assign open_o   = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         left_q <= '0;
      end else if (commit_o) begin
         open_q <= 1'b0;
         left_q <= '0;
      end else if (open_q) begin
         if (left_q == '0) open_q <= 1'b0;
         else              left_q <= left_q - CW'(1);
      end else if (arm_req) begin
         open_q <= 1'b1;
         left_q <= CW'(WINDOW - 1);
      end
   end
endmodule

// File: rtl/cs_sel_reg.sv
module cs_sel_reg #(
   parameter int SEL_W         = 4,
   parameter int MAX_CODE      = 8,
   parameter int FUSED_CODE    = 3,
   parameter bit HOLD_RESERVED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_i,
   input  logic             commit_i,
   input  logic [SEL_W-1:0] code_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             restart_o
);
   localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_CODE);
   localparam logic [SEL_W-1:0] CFG_CODE = SEL_W'(FUSED_CODE);

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] next_code;
   logic             legal;

   generate
      if (HOLD_RESERVED) begin : g_hold
         assign legal     = (code_i <= TOP_CODE);
         assign next_code = code_i;
      end else begin : g_clamp
         assign legal     = 1'b1;
         assign next_code = (code_i > TOP_CODE) ? TOP_CODE : code_i;
      end
   endgenerate

   assign restart_o = commit_i && legal && (next_code != sel_q);
   assign sel_o     = sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         sel_q <= cfg_i ? CFG_CODE : '0;
      else if (restart_o) sel_q <= next_code;
   end
endmodule

// File: rtl/cs_pow2_divider.sv
module cs_pow2_divider #(
   parameter int SEL_W    = 4,
   parameter int MAX_CODE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

   generate
      if (MAX_CODE == 0) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W:0]   span;
         logic             wrap;

         assign span   = ((CNT_W+1)'(1) << sel_i) - (CNT_W+1)'(1);
         assign wrap   = ({1'b0, cnt_q} == span);
         assign tick_o = (cnt_q == '0);

         always_ff @(posedge clk) begin
            if (!rst_n || restart_i) cnt_q <= '0;
            else if (wrap)           cnt_q <= '0;
            else                     cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/clk_scaler_guarded.sv
module clk_scaler_guarded #(
   parameter int DATA_W        = 8,
   parameter int SEL_W         = 4,
   parameter int GATE_BIT      = 7,
   parameter int WINDOW        = 4,
   parameter int MAX_CODE      = 8,
   parameter int FUSED_CODE    = 3,
   parameter bit HOLD_RESERVED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_div8,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              tick_o
);
   import clk_scaler_pkg::*;

   generate
      if (GATE_BIT < SEL_W || GATE_BIT >= DATA_W) begin : g_bad_gate
         $error("gate bit must sit above the select field and inside the word");
      end
      if (WINDOW < 1) begin : g_bad_window
         $error("unlock window must be at least one cycle");
      end
      if (MAX_CODE >= (1 << SEL_W) || FUSED_CODE > MAX_CODE) begin : g_bad_code
         $error("select codes do not fit the select field");
      end
   endgenerate

   logic             gate_open;
   logic             commit;
   logic [SEL_W-1:0] sel;
   logic             restart;

   cs_unlock_gate #(
      .DATA_W   (DATA_W),
      .GATE_BIT (GATE_BIT),
      .WINDOW   (WINDOW)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .open_o   (gate_open),
      .commit_o (commit)
   );

   cs_sel_reg #(
      .SEL_W         (SEL_W),
      .MAX_CODE      (MAX_CODE),
      .FUSED_CODE    (FUSED_CODE),
      .HOLD_RESERVED (HOLD_RESERVED)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (cfg_div8),
      .commit_i  (commit),
      .code_i    (wr_data[SEL_W-1:0]),
      .sel_o     (sel),
      .restart_o (restart)
   );

   cs_pow2_divider #(
      .SEL_W    (SEL_W),
      .MAX_CODE (MAX_CODE)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .sel_i     (sel),
      .tick_o    (tick_o)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_rd
      if (bit_role(i, GATE_BIT, SEL_W) == ROLE_GATE) begin : g_gate
         assign rd_data[i] = gate_open;
      end else if (bit_role(i, GATE_BIT, SEL_W) == ROLE_SEL) begin : g_sel
         assign rd_data[i] = sel[i];
      end else begin : g_rsv
         assign rd_data[i] = 1'b0;
      end
   end
endmodule

// File: rtl/clk_scaler_guarded_chk.sv
module clk_scaler_guarded_chk #(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 4,
   parameter int GATE_BIT = 7,
   parameter int WINDOW   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              tick_o
);
   import clk_scaler_pkg::*;

   localparam int AW = $clog2(WINDOW + 2);
   localparam logic [DATA_W-1:0] ARM_WORD = DATA_W'(1) << GATE_BIT;
   localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(reserved_mask(DATA_W, GATE_BIT, SEL_W));

   logic          open_s;
   logic          sel_wr;
   logic [AW-1:0] age_q;

   assign open_s = rd_data[GATE_BIT];
   assign sel_wr = wr_en && !wr_data[GATE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)      age_q <= '0;
      else if (open_s) age_q <= age_q + AW'(1);
      else             age_q <= '0;
   end

   assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & RSV_MASK) == '0);

   assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_s && wr_en && wr_data == ARM_WORD) |=> open_s);

   assert_no_stray_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_s && !(wr_en && wr_data == ARM_WORD)) |=> !open_s);

   assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      open_s |-> (age_q < AW'(WINDOW)));

   assert_commit_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (open_s && sel_wr) |=> !open_s);

   assert_window_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (open_s && !sel_wr && age_q < AW'(WINDOW - 1)) |=> open_s);

   assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !open_s |=> $stable(rd_data[SEL_W-1:0]));

   assert_div1_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[SEL_W-1:0] == '0) |-> tick_o);
endmodule

bind clk_scaler_guarded clk_scaler_guarded_chk #(
   .DATA_W   (DATA_W),
   .SEL_W    (SEL_W),
   .GATE_BIT (GATE_BIT),
   .WINDOW   (WINDOW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .tick_o  (tick_o)
);

// File: tb/clk_scaler_guarded_test.sv
`timescale 1ns/1ps
module clk_scaler_guarded_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_div8 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       tick_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   clk_scaler_guarded uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_div8 (cfg_div8),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .tick_o   (tick_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic do_reset(input logic cfg);
      cfg_div8 = cfg;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   // tick must be high at offset 0 and every n cycles after, low elsewhere
   task automatic phase_check(input string req, input int n);
      int miss = 0;
      int first = -1;
      for (int i = 0; i <= 2 * n; i++) begin
         if (tick_o != ((i % n) == 0)) begin
            miss++;
            if (first < 0) first = i;
         end
         @(negedge clk);
      end
      check(req, miss, 0);
      if (miss != 0) $display("  first bad offset %0d for period %0d", first, n);
   endtask

   task automatic count_ticks(input string req, input int n);
      int hits = 0;
      for (int i = 0; i < 4 * n; i++) begin
         if (tick_o) hits++;
         @(negedge clk);
      end
      check(req, hits, 4);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      int exp_sel;
      int nxt;
      @(negedge clk);

      // R7, R8, R9, R10, R11: sweep all codes under both reset configurations
      for (int cfg = 0; cfg < 2; cfg++) begin
         do_reset(cfg[0]);
         exp_sel = (cfg == 1) ? 3 : 0;
         check("R7 reset code", rd_data, exp_sel);
         count_ticks("R10 reset period", 1 << exp_sel);
         for (int code = 0; code < 16; code++) begin
            wr(8'h80);
            check("R2 armed read", rd_data, 8'h80 | exp_sel);
            wr(8'(code));
            nxt = (code <= 8) ? code : exp_sel;
            check("R8 R9 code load", rd_data, nxt);
            if (nxt != exp_sel || nxt == 0) phase_check("R11 R10 restart phase", 1 << nxt);
            else                            count_ticks("R9 R10 held period", 1 << nxt);
            exp_sel = nxt;
         end
      end

      // R6: select writes while locked are dropped
      do_reset(1'b0);
      wr(8'h05);
      check("R6 locked write", rd_data, 8'h00);
      wr(8'h7F);
      check("R6 locked write full", rd_data, 8'h00);
      check("R10 div1 tick", tick_o, 1);

      // R2: non-exact arm patterns do not open the gate
      wr(8'h81);
      check("R2 0x81 no arm", rd_data, 8'h00);
      wr(8'h02);
      check("R2 no load after 0x81", rd_data, 8'h00);
      wr(8'h90);
      wr(8'h02);
      check("R2 no load after 0x90", rd_data, 8'h00);

      // R1 + R4: reserved bits ignored, select write closes window
      wr(8'h80);
      wr(8'h72);
      check("R1 R4 reserved ignored, flag closed", rd_data, 8'h02);
      wr(8'h04);
      check("R4 second write after close dropped", rd_data, 8'h02);

      // R3: last accepted edge is the fourth after arming
      wr(8'h80);
      idle(3);
      check("R3 flag still set", rd_data, 8'h82);
      wr(8'h01);
      check("R3 fourth edge accepted", rd_data, 8'h01);
      wr(8'h80);
      idle(4);
      check("R3 flag expired", rd_data, 8'h01);
      wr(8'h03);
      check("R3 fifth edge refused", rd_data, 8'h01);

      // R5: re-arm does not extend or clear; bit-7 writes leave flag set
      wr(8'h80);
      wr(8'h80);
      check("R5 re-arm keeps flag", rd_data, 8'h81);
      wr(8'h86);
      check("R5 bit7 write ignored", rd_data, 8'h81);
      idle(1);
      wr(8'h02);
      check("R5 fourth edge still accepted", rd_data, 8'h02);
      wr(8'h80);
      wr(8'h80);
      idle(3);
      wr(8'h05);
      check("R5 no window extension", rd_data, 8'h02);

      // R9: reserved code closes the window but holds the code
      wr(8'h80);
      wr(8'h0F);
      check("R9 reserved code held, window closed", rd_data, 8'h02);
      wr(8'h06);
      check("R9 closed after reserved code", rd_data, 8'h02);
      count_ticks("R10 period after reserved", 4);

      done = 1'b1;
      finish_run();
   end
endmodule